// File: doc/BRIEF.md
# Retriggerable Gated One-Shot

This block is a clocked one-shot pulse generator with a retrigger window and a clear override. Three asynchronous controls drive it: a gate that is active when low, a gate that is active when high, and a clear that is active when low. Each control is resynchronised to the clock, and the block then watches it for edges. When a qualified edge arrives, a down-counter loads the requested pulse length. The true output stays high until that count runs out. A second output always carries the logical inverse of the true output.

Three events start a pulse:
- the high gate rises while the low gate sits low;
- the low gate falls while the high gate sits high;
- the clear returns high while both gates are already in their active state.

A qualified edge that arrives while a pulse is running restarts the count, so a steady stream of triggers can hold the output high without a break. The restart is taken only once at least 30 % of the latched length has passed since the last trigger that was taken. A trigger that comes sooner than that is dropped. While the clear is low, the pulse ends and no trigger is taken.

The block is meant for timeout, debounce-stretch and watchdog-style pulse generation inside a synchronous design. Two copies can sit side by side when two independent channels are needed.

Top module: `retrig_oneshot`

## Requirements
- R1: While reset is asserted and after it is released with the controls idle (low gate high, high gate low, clear high), `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: With `gate_lo_i` low, a 0-to-1 change on `gate_hi_i` starts a pulse. `pulse_o` rises on the third rising clock edge after the input change.
- R3: With `gate_hi_i` high, a 1-to-0 change on `gate_lo_i` starts a pulse, with the same three-edge latency.
- R4: With `gate_lo_i` low and `gate_hi_i` high, a 0-to-1 change on `clear_n_i` starts a pulse, with the same three-edge latency.
- R5: A pulse that is not retriggered and not cleared lasts exactly L clock cycles, where L is `pulse_len_i`. The value 0 gives a pulse of 1 cycle.
- R6: A trigger that arrives during a pulse, at least G = ceil(3*L/10) cycles after the previous accepted trigger, is accepted. The pulse then ends L cycles after that trigger, with no low cycle in between.
- R7: A trigger that arrives during a pulse, fewer than G cycles after the previous accepted trigger, is ignored. The pulse ends L cycles after the earlier trigger.
- R8: While the synchronised clear is low, `pulse_o` is 0 and `pulse_n_o` is 1. A clear that falls during a pulse drops `pulse_o` on the third edge after the input change. Gate edges seen while clear is low start nothing.
- R9: A change on `gate_hi_i` while `gate_lo_i` is high starts no pulse. A change on `gate_lo_i` while `gate_hi_i` is low starts no pulse. The output stays at 0.
- R10: The pulse length is captured when a trigger is accepted. A change of `pulse_len_i` during a pulse does not alter that pulse.
- R11: `pulse_n_o` is the inverse of `pulse_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| gate_lo_i | input | 1 | Active-low gate; its falling edge triggers while `gate_hi_i` is high |
| gate_hi_i | input | 1 | Active-high gate; its rising edge triggers while `gate_lo_i` is low |
| clear_n_i | input | 1 | Active-low clear; its rising edge triggers when both gates are active |
| pulse_len_i | input | CNT_W | Pulse length in clock cycles (0 is taken as 1) |
| pulse_o | output | 1 | One-shot output, high during the pulse |
| pulse_n_o | output | 1 | Inverse of `pulse_o` |

## Verification
Clear and triggering can land in the same cycle, because the return of the clear is itself a trigger when both gates are active. The bench provokes this in two ways. It lowers the clear in the middle of a running pulse and toggles the high gate while the clear is held low. It then releases the clear once with the low gate inactive, where no pulse may follow, and once with both gates active, where exactly one full pulse must follow. Each case is judged by the number of high output cycles, the cycle of the first high sample and the number of rising output edges seen at the ports.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef struct packed {
    logic gate_lo;
    logic gate_hi;
    logic clr_n;
  } ctl_t;

  localparam int CTL_W = 3;
  localparam logic [CTL_W-1:0] CTL_IDLE = 3'b101;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int                W       = 3,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end

endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t cur_i,
  output logic trig_o,
  output logic clr_ok_o
);

  ctl_t prev_q;
  logic b_rise, a_fall, c_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= ctl_t'(CTL_IDLE);
    else        prev_q <= cur_i;
  end

  always_comb begin
    b_rise = cur_i.gate_hi & ~prev_q.gate_hi;
    a_fall = ~cur_i.gate_lo & prev_q.gate_lo;
    c_rise = cur_i.clr_n & ~prev_q.clr_n;
    trig_o = cur_i.clr_n &
             ((~cur_i.gate_lo & b_rise) |
              (cur_i.gate_hi & a_fall) |
              (~cur_i.gate_lo & cur_i.gate_hi & c_rise));
  end

  assign clr_ok_o = cur_i.clr_n;

endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             clr_ok_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             q_o,
  output logic             qn_o
);

  localparam int GW = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, hold_q, hold_d, len_eff, gap_ld;
  logic [GW-1:0]    tri_len, gap_w;
  logic             q_q, qn_q, q_d, busy, accept, en;

  // Minimum retrigger spacing: ceil(3*L/10); the hold counter starts at gap-1.
  always_comb begin
    len_eff = (len_i == '0) ? CNT_W'(1) : len_i;
    tri_len = {2'b00, len_eff} + {1'b0, len_eff, 1'b0};
    gap_w   = (tri_len + GW'(9)) / GW'(10);
    gap_ld  = (gap_w == '0) ? '0 : CNT_W'(gap_w - GW'(1));
  end

  assign busy   = (cnt_q != '0);
  assign accept = trig_i & clr_ok_i & (~busy | (hold_q == '0));
  assign en     = busy | accept | ~clr_ok_i | (hold_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (hold_q != '0) hold_d = hold_q - CNT_W'(1);
    if (busy)         cnt_d  = cnt_q - CNT_W'(1);
    if (accept) begin
      cnt_d  = len_eff;
      hold_d = gap_ld;
    end
    if (!clr_ok_i) begin
      cnt_d  = '0;
      hold_d = '0;
    end
    q_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      q_q    <= 1'b0;
      qn_q   <= 1'b1;
    end else if (en) begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      q_q    <= q_d;
      qn_q   <= ~q_d;
    end
  end

  assign q_o  = q_q;
  assign qn_o = qn_q;

  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (q_q && cnt_q == $past(len_eff)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok_i |=> (!q_q && qn_q));

  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && clr_ok_i && busy && hold_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> !q_q);

  assert_complement_R11: assert property (@(posedge clk) disable iff (!rst_n)
    q_q != qn_q);

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_lo_i,
  input  logic             gate_hi_i,
  input  logic             clear_n_i,
  input  logic [CNT_W-1:0] pulse_len_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  logic [CTL_W-1:0] raw_ctl, sync_ctl;
  logic             trig, clr_ok;

  assign raw_ctl = {gate_lo_i, gate_hi_i, clear_n_i};

  os_sync #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_ctl),
    .q_o   (sync_ctl)
  );

  os_trig_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_i    (ctl_t'(sync_ctl)),
    .trig_o   (trig),
    .clr_ok_o (clr_ok)
  );

  os_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig),
    .clr_ok_i (clr_ok),
    .len_i    (pulse_len_i),
    .q_o      (pulse_o),
    .qn_o     (pulse_n_o)
  );

  assert_rise_needs_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(trig));

endmodule

// File: tb/retrig_oneshot_test.sv
`timescale 1ns/1ps
module retrig_oneshot_test;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic gate_lo, gate_hi, clr_n;
  logic [CNT_W-1:0] plen;
  logic pulse_o, pulse_n_o;

  int n_run = 0, n_fail = 0;
  int cyc, hi_cnt, first_hi, rises, compl_bad;
  logic prev_hi;
  bit done = 1'b0;

  always #5 clk = ~clk;

  retrig_oneshot #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .gate_lo_i(gate_lo), .gate_hi_i(gate_hi),
    .clear_n_i(clr_n), .pulse_len_i(plen), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
  );

  // Output observer, 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    cyc++;
    if (pulse_o) begin
      hi_cnt++;
      if (first_hi == 0) first_hi = cyc;
      if (!prev_hi) rises++;
    end
    if (pulse_o == pulse_n_o) compl_bad++;
    prev_hi = pulse_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    cyc = 0; hi_cnt = 0; first_hi = 0; rises = 0; prev_hi = pulse_o;
  endtask

  task automatic expect_pulse(input string req, input int exp_w);
    chk(hi_cnt == exp_w, {req, " width"}, hi_cnt, exp_w);
    chk(rises == (exp_w > 0 ? 1 : 0), {req, " rises"}, rises, exp_w > 0 ? 1 : 0);
    if (exp_w > 0) chk(first_hi == 3, {req, " latency"}, first_hi, 3);
  endtask

  task automatic to_idle();
    gate_hi = 1'b0; tick(1); gate_lo = 1'b1; clr_n = 1'b1; plen = 16'd20; tick(30);
  endtask

  // R2 and R5: high gate rises with low gate held low
  task automatic t_b_rise();
    gate_lo = 1'b0; tick(5);
    clear_obs(); gate_hi = 1'b1; tick(30);
    expect_pulse("R2/R5", 20);
    to_idle();
  endtask

  // R3: low gate falls with high gate held high
  task automatic t_a_fall();
    gate_hi = 1'b1; tick(5);
    clear_obs(); gate_lo = 1'b0; tick(30);
    expect_pulse("R3", 20);
    to_idle();
  endtask

  // R4: clear returns high with both gates active
  task automatic t_clr_rise();
    clr_n = 1'b0; tick(4);
    gate_lo = 1'b0; gate_hi = 1'b1; tick(5);
    clear_obs(); clr_n = 1'b1; tick(30);
    expect_pulse("R4", 20);
    to_idle();
  endtask

  // R5: zero length counts as one cycle
  task automatic t_zero_len();
    plen = '0; gate_lo = 1'b0; tick(5);
    clear_obs(); gate_hi = 1'b1; tick(15);
    expect_pulse("R5 zero", 1);
    to_idle();
  endtask

  // R6/R7: second trigger d cycles after the first, L=20, G=6
  task automatic t_retrig(input int d, input bit taken);
    gate_lo = 1'b0; tick(5);
    clear_obs(); gate_hi = 1'b1; tick(2);
    gate_hi = 1'b0; tick(d - 2);
    gate_hi = 1'b1; tick(40);
    if (taken) expect_pulse($sformatf("R6 d=%0d", d), d + 20);
    else       expect_pulse($sformatf("R7 d=%0d", d), 20);
    to_idle();
  endtask

  // R6: a stream of spaced triggers keeps the output high
  task automatic t_stretch();
    gate_lo = 1'b0; tick(5);
    clear_obs(); gate_hi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(2); gate_hi = 1'b0; tick(8); gate_hi = 1'b1;
    end
    tick(40);
    expect_pulse("R6 stretch", 60);
    to_idle();
  endtask

  // R8: clear cuts a running pulse and blocks triggers while low
  task automatic t_clear();
    gate_lo = 1'b0; tick(5);
    clear_obs(); gate_hi = 1'b1; tick(5);
    clr_n = 1'b0; tick(4);
    chk(pulse_o == 1'b0 && pulse_n_o == 1'b1, "R8 forced level", pulse_o, 0);
    gate_hi = 1'b0; tick(3); gate_hi = 1'b1; tick(3);
    gate_lo = 1'b1; tick(4); clr_n = 1'b1; tick(30);
    expect_pulse("R8 cut", 5);
    to_idle();
  endtask

  // R9: edges with the other gate inactive start nothing
  task automatic t_ignore();
    clear_obs();
    gate_hi = 1'b1; tick(4); gate_hi = 1'b0; tick(4); gate_hi = 1'b1; tick(4);
    gate_hi = 1'b0; tick(4);
    gate_lo = 1'b0; tick(4); gate_lo = 1'b1; tick(4); gate_lo = 1'b0; tick(4);
    gate_lo = 1'b1; tick(10);
    chk(hi_cnt == 0, "R9 no pulse", hi_cnt, 0);
    to_idle();
  endtask

  // R10: length change after acceptance has no effect
  task automatic t_len_latch();
    plen = 16'd8; gate_lo = 1'b0; tick(5);
    clear_obs(); gate_hi = 1'b1; tick(4);
    plen = 16'd50; tick(70);
    expect_pulse("R10", 8);
    to_idle();
  endtask

  initial begin
    rst_n = 1'b0; gate_lo = 1'b1; gate_hi = 1'b0; clr_n = 1'b1; plen = 16'd20;
    cyc = 0; hi_cnt = 0; first_hi = 0; rises = 0; compl_bad = 0; prev_hi = 1'b0;
    tick(3);
    chk(pulse_o == 1'b0, "R1 q in reset", pulse_o, 0);
    chk(pulse_n_o == 1'b1, "R1 qn in reset", pulse_n_o, 1);
    rst_n = 1'b1;
    compl_bad = 0;
    tick(6);
    chk(pulse_o == 1'b0 && pulse_n_o == 1'b1, "R1 after release", pulse_o, 0);
    t_b_rise();
    t_a_fall();
    t_clr_rise();
    t_zero_len();
    t_retrig(10, 1'b1);
    t_retrig(6, 1'b1);
    t_retrig(5, 1'b0);
    t_retrig(4, 1'b0);
    t_stretch();
    t_clear();
    t_ignore();
    t_len_latch();
    chk(compl_bad == 0, "R11 complement", compl_bad, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule